// File: doc/BRIEF.md
# Time-Multiplexed Crosspoint Audio Mixer

This block mixes six audio inputs into six outputs once per sample period. Each input is a 24-bit signed sample, written into a staging register by channel number. Each of the 36 input-to-output crosspoints has its own 24-bit signed gain. A frame strobe latches the staged samples and the pending gain set. One shared multiply-accumulate datapath then builds each output as the gain-weighted sum of all six inputs, in a 56-bit accumulator.

Each finished sum is scaled back from the gain format, rounded and clipped to 24 bits. It then leaves on a single output bus, tagged with its output number and a one-cycle valid pulse. A frame takes 36 clock cycles, which is far inside a 48 kHz period at any practical clock rate. Gains are written at any time, but only take effect at the next frame. A strobe that arrives while a frame is still computing is dropped and recorded in a sticky flag.

Top module: `xpoint_mixer`

## Requirements
- R1: After reset out_valid, overrun and out_data are 0 and all 36 gains are 0, so a frame started before any gain write yields six zero outputs.
- R2: Output o equals the sum over k of in[k]·g[o][k]. Gains are signed Q1.22, so 0x400000 is unity and passes a sample unchanged, 0x200000 halves it and 0xC00000 inverts it.
- R3: The 22 discarded fraction bits are rounded half up (add 2^21, then arithmetic shift), so +1.5 gives 2 and −1.5 gives −1.
- R4: A result above 8388607 leaves as 8388607, and a result below −8388608 leaves as −8388608.
- R5: Each accepted frame produces exactly six out_valid pulses of one cycle each. Output k is presented on the clock edge 6·(k+1) edges after the edge that accepted the strobe.
- R6: Within a frame the results appear with out_idx 0, 1, 2, 3, 4, 5 in that order.
- R7: A gain write (cf_we with row cf_out = output, column cf_in = input) is held pending and takes effect only at the next accepted strobe. A frame already computing keeps the gains it started with.
- R8: Samples written with in_we are staged. The accepted strobe copies them into the frame, so a write during a computing frame changes only the next frame.
- R9: A strobe while a frame is computing sets overrun, which stays 1 until reset. The strobe starts no new frame and produces no extra outputs.
- R10: Any input can be routed to any output with any gain. The bench checks a full matrix of distinct gains against an arithmetic model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Sample-period strobe, starts a frame |
| in_we | input | 1 | Stage an input sample |
| in_idx | input | 3 | Input channel for in_data |
| in_data | input | 24 | Signed input sample |
| cf_we | input | 1 | Write a pending gain |
| cf_out | input | 3 | Gain row (output channel) |
| cf_in | input | 3 | Gain column (input channel) |
| cf_data | input | 24 | Signed Q1.22 gain |
| out_valid | output | 1 | One-cycle result strobe |
| out_idx | output | 3 | Output channel of out_data |
| out_data | output | 24 | Rounded, clipped result |
| overrun | output | 1 | Sticky frame overrun flag |

## Verification
The hardest case to reach from the ports is a change to gains or samples that lands while a frame is in flight. Only the frame boundary may make that change visible. The bench starts a frame and, a few cycles later, writes both a new gain and a new sample. It then checks that every output of that frame still matches the old values, and that the following frame reflects the new ones. The overrun case is reached the same way: a second strobe is sent in the middle of the 36-cycle computation, and the bench counts the valid pulses over a long idle window afterwards.

// File: rtl/xpoint_mixer.sv
module xpoint_mixer #(
  parameter int CH    = 6,
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int AW    = 56,
  parameter int CFRAC = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_go,
  input  logic                    in_we,
  input  logic [$clog2(CH)-1:0]   in_idx,
  input  logic signed [DW-1:0]    in_data,
  input  logic                    cf_we,
  input  logic [$clog2(CH)-1:0]   cf_out,
  input  logic [$clog2(CH)-1:0]   cf_in,
  input  logic signed [CW-1:0]    cf_data,
  output logic                    out_valid,
  output logic [$clog2(CH)-1:0]   out_idx,
  output logic signed [DW-1:0]    out_data,
  output logic                    overrun
);
  localparam int IW = $clog2(CH);
  localparam int NW = $clog2(CH*CH);
  localparam int PW = DW + CW;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CFRAC-1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW-1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [DW-1:0] x_stage [CH];
  logic signed [DW-1:0] x_cur   [CH];
  logic signed [CW-1:0] g_pend  [CH*CH];
  logic signed [CW-1:0] g_act   [CH*CH];

  logic          busy;
  logic [IW-1:0] oi, ii;
  logic signed [AW-1:0] acc;

  wire [NW-1:0]          gidx = NW'(oi) * NW'(CH) + NW'(ii);
  wire [NW-1:0]          widx = NW'(cf_out) * NW'(CH) + NW'(cf_in);
  wire signed [PW-1:0]   prod = x_cur[ii] * g_act[gidx];
  wire signed [AW-1:0]   sum  = acc + {{(AW-PW){prod[PW-1]}}, prod};
  wire signed [AW-1:0]   shr  = (sum + HALF) >>> CFRAC;
  wire signed [DW-1:0]   yq   = (shr > MAXV) ? MAXV[DW-1:0] :
                                (shr < MINV) ? MINV[DW-1:0] : shr[DW-1:0];
  wire                   last_in  = (ii == IW'(CH-1));
  wire                   last_out = (oi == IW'(CH-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < CH; k++) x_stage[k] <= '0;
      for (int k = 0; k < CH*CH; k++) g_pend[k] <= '0;
    end else begin
      if (in_we && in_idx < IW'(CH)) x_stage[in_idx] <= in_data;
      if (cf_we && cf_out < IW'(CH) && cf_in < IW'(CH)) g_pend[widx] <= cf_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < CH; k++) x_cur[k] <= '0;
      for (int k = 0; k < CH*CH; k++) g_act[k] <= '0;
      busy      <= 1'b0;
      oi        <= '0;
      ii        <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (frame_go && busy) overrun <= 1'b1;
      if (!busy) begin
        if (frame_go) begin
          x_cur <= x_stage;
          g_act <= g_pend;
          busy  <= 1'b1;
          oi    <= '0;
          ii    <= '0;
          acc   <= '0;
        end
      end else if (last_in) begin
        out_valid <= 1'b1;
        out_idx   <= oi;
        out_data  <= yq;
        acc       <= '0;
        ii        <= '0;
        oi        <= oi + IW'(1);
        if (last_out) busy <= 1'b0;
      end else begin
        acc <= sum;
        ii  <= ii + IW'(1);
      end
    end
  end
endmodule

// File: rtl/xpoint_mixer_chk.sv
module xpoint_mixer_chk #(
  parameter int CH = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_go,
  input logic                  busy,
  input logic                  out_valid,
  input logic [$clog2(CH)-1:0] out_idx,
  input logic                  overrun
);
  localparam int IW = $clog2(CH);
  logic [IW-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) last_idx <= '0;
    else if (out_valid) last_idx <= out_idx;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && busy) |=> overrun); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx < IW'(CH))); // R6
  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != '0) |-> (last_idx == out_idx - IW'(1))); // R6
endmodule

bind xpoint_mixer xpoint_mixer_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .busy(busy),
  .out_valid(out_valid), .out_idx(out_idx), .overrun(overrun)
);

// File: tb/xpoint_mixer_test.sv
module xpoint_mixer_test;
  logic clk = 0, rst_n = 0;
  logic frame_go = 0, in_we = 0, cf_we = 0;
  logic [2:0] in_idx = 0, cf_out = 0, cf_in = 0;
  logic signed [23:0] in_data = 0, cf_data = 0;
  logic out_valid, overrun;
  logic [2:0] out_idx;
  logic signed [23:0] out_data;

  xpoint_mixer uut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, vcount = 0;
  int got [6];
  int ord [6];
  int vcyc [6];
  int xs [6];
  int gs [36];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && vcount < 6) begin
      got[out_idx] = out_data;
      ord[vcount]  = out_idx;
      vcyc[vcount] = cyc;
    end
    if (out_valid) vcount++;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // x, gain, expected output 0
  localparam int VEC [8][3] = '{
    '{1000, 4194304, 1000},          // R2 unity
    '{-1000, 4194304, -1000},        // R2 unity negative
    '{1000, 2097152, 500},           // R2 half
    '{3, 2097152, 2},                // R3 +1.5
    '{-3, 2097152, -1},              // R3 -1.5
    '{5000000, 8388607, 8388607},    // R4 clip high
    '{-5000000, 8388607, -8388608},  // R4 clip low
    '{-8388608, -4194304, 8388607}   // R4 invert full scale
  };

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(int k, int v);
    @(negedge clk);
    in_we = 1; in_idx = 3'(k); in_data = 24'(v);
    xs[k] = v;
    @(negedge clk);
    in_we = 0;
  endtask

  task automatic set_g(int o, int i, int v);
    @(negedge clk);
    cf_we = 1; cf_out = 3'(o); cf_in = 3'(i); cf_data = 24'(v);
    gs[o*6+i] = v;
    @(negedge clk);
    cf_we = 0;
  endtask

  int s0;
  task automatic start_frame();
    @(negedge clk);
    vcount = 0;
    frame_go = 1;
    s0 = cyc;
    @(negedge clk);
    frame_go = 0;
  endtask

  task automatic wait_frame();
    for (int t = 0; t < 200 && vcount < 6; t++) @(negedge clk);
  endtask

  function automatic int ref_out(int o);
    longint s = 0;
    longint r;
    for (int k = 0; k < 6; k++) s += longint'(xs[k]) * longint'(gs[o*6+k]);
    r = (s + 64'sd2097152) >>> 22;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  initial begin
    for (int k = 0; k < 6; k++) xs[k] = 0;
    for (int k = 0; k < 36; k++) gs[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 data", int'(out_data), 0);

    for (int k = 0; k < 6; k++) set_in(k, 1000 * (k + 1));
    start_frame();
    wait_frame();
    for (int o = 0; o < 6; o++) check("R1 zero gains", got[o], 0);
    check("R5 count", vcount, 6);
    for (int k = 0; k < 6; k++) check("R6 order", ord[k], k);
    for (int k = 0; k < 6; k++) check("R5 timing", vcyc[k] - s0, 6*k + 7);

    for (int k = 1; k < 6; k++) set_in(k, 0);
    foreach (VEC[v]) begin
      set_in(0, VEC[v][0]);
      set_g(0, 0, VEC[v][1]);
      start_frame();
      wait_frame();
      check("R2/R3/R4 vector", got[0], VEC[v][2]);
      for (int o = 1; o < 6; o++) check("R2 idle outputs", got[o], 0);
    end

    // R10 full routing
    for (int k = 0; k < 6; k++) set_in(k, (k % 2 ? -1 : 1) * (123457 * (k + 1)));
    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 6; i++)
        set_g(o, i, (o * 6 + i - 17) * 97531);
    start_frame();
    wait_frame();
    for (int o = 0; o < 6; o++) check("R10 matrix", got[o], ref_out(o));

    // R7 / R8: writes during a computing frame
    begin
      int old_ref [6];
      for (int o = 0; o < 6; o++) old_ref[o] = ref_out(o);
      start_frame();
      set_g(2, 3, 4194304);
      set_in(3, 777);
      wait_frame();
      for (int o = 0; o < 6; o++) check("R7/R8 frame unchanged", got[o], old_ref[o]);
      start_frame();
      wait_frame();
      for (int o = 0; o < 6; o++) check("R7/R8 next frame", got[o], ref_out(o));
    end
    check("R9 no false overrun", int'(overrun), 0);

    // R9 overrun
    start_frame();
    repeat (3) @(negedge clk);
    frame_go = 1;
    @(negedge clk);
    frame_go = 0;
    wait_frame();
    repeat (60) @(negedge clk);
    check("R9 overrun set", int'(overrun), 1);
    check("R9 no extra outputs", vcount, 6);
    repeat (10) @(negedge clk);
    check("R9 overrun sticky", int'(overrun), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule